// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (a bit clock, a word clock that tells the two channels apart, and one data line) and turns it into parallel sample pairs. All of its logic runs on the rising edge of the incoming bit clock, which also serves as the block clock. A static format input picks the framing. In the first mode, words of up to 24 bits start one bit clock after each word-clock change. In the second mode, 16-bit words are right-justified against the word-clock change. The two modes use opposite word-clock polarities to mark the left channel.

Each completed frame appears as a registered left/right pair with a single-cycle valid strobe. Words shorter than 24 bits are MSB-aligned and zero-filled. If both halves of a frame hold exactly 16 bit clocks, the block treats the frame as packed 16-bit data and flags it. This decision is made again for every frame. After reset the block waits until it sees a complete left half and a complete right half, each bounded by observed word-clock changes, before it produces any output.

Top module: `serial_audio_rx`

## Requirements
- R1: Synchronous reset clears the strobe, both sample outputs and the packed flag. No pair is produced until a left half and the following right half have both started at an observed word-clock change, so a partial first frame is dropped.
- R2: With `fmt_i2s` = 1, word clock low marks the left channel. The MSB is taken at the second rising bit-clock edge after a word-clock change, and later bits follow MSB first, up to 24 bits. The last of these may fall on the first edge of the next half.
- R3: With `fmt_i2s` = 1, a word shorter than 24 bits appears MSB-aligned in bits 23 down to 24-n, and all lower bits are zero.
- R4: With `fmt_i2s` = 1, data bits after the 24th bit of a half have no effect on the output.
- R5: With `fmt_i2s` = 0, word clock high marks the left channel. The word is the 16 bits sampled on the 16 rising edges just before the word-clock change, MSB first. It is placed in bits 23:8, and bits 7:0 are zero.
- R6: With `fmt_i2s` = 0, any bit clocks in a half before its last 16 have no effect on the output.
- R7: `pair_short` is 1 exactly when both halves of the reported frame lasted 16 bit clocks. In that case bits 7:0 of both samples are zero. The flag is decided again for every frame.
- R8: `pair_valid` is high for a single cycle. It goes high one cycle after the rising edge at which the left-channel word-clock level is first sampled after a right half. The outputs hold their values between strobes.
- R9: The format input selects both the framing and the word-clock polarity, and the same receiver decodes both kinds of stream after a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Serial bit clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s | input | 1 | Framing select: 1 = delayed-MSB framing up to 24 bits, 0 = 16-bit right-justified |
| ws | input | 1 | Word clock (channel select) |
| sdata | input | 1 | Serial data, MSB first |
| pair_valid | output | 1 | One-cycle strobe: a new sample pair is on the outputs |
| left_smp | output | 24 | Left-channel sample, MSB-aligned |
| right_smp | output | 24 | Right-channel sample, MSB-aligned |
| pair_short | output | 1 | Reported frame was packed 16-clock halves |

## Verification
The bench drives the word clock and data on falling bit-clock edges, so every rising edge sees stable inputs. A pair is due in the cycle right after the rising edge that first samples the left-channel word-clock level following a right half. The bench samples outputs on falling edges and checks each strobe against a queue of expected pairs that the stimulus tasks build from the requirements. A strobe with an empty queue, or a strobe in two adjacent samples, counts as a failure. After each stream, the bench waits a few idle cycles and then checks that every queued pair has arrived.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SMP_W     = 24;
    localparam int RJ_W      = 16;
    localparam int PACK_CLKS = 16;
    localparam int HCNT_W    = 7;

    typedef enum logic {
        FMT_RJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    // word-clock level that marks the left channel in each framing
    function automatic logic left_level(input fmt_e f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/sarx_half_timer.sv
module sarx_half_timer #(
    parameter int HCNT_W    = sarx_pkg::HCNT_W,
    parameter int PACK_CLKS = sarx_pkg::PACK_CLKS
) (
    input  logic clk,
    input  logic rst,
    input  logic ws,
    output logic ws_edge,
    output logic half_whole,
    output logic half_is16
);
    localparam logic [HCNT_W-1:0] CNT_MAX = '1;
    localparam logic [HCNT_W-1:0] CNT_PK  = HCNT_W'(PACK_CLKS - 1);

    logic              ws_q;
    logic              armed;
    logic              started;
    logic [HCNT_W-1:0] hcnt;

    // a change is only trusted once a previous level has been sampled
    assign ws_edge    = armed && (ws != ws_q);
    assign half_whole = started;
    assign half_is16  = (hcnt == CNT_PK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q    <= 1'b0;
            armed   <= 1'b0;
            started <= 1'b0;
            hcnt    <= '0;
        end else begin
            ws_q  <= ws;
            armed <= 1'b1;
            if (ws_edge) begin
                hcnt    <= '0;
                started <= 1'b1;
            end else if (hcnt != CNT_MAX) begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sarx_i2s_capture.sv
module sarx_i2s_capture #(
    parameter int SMP_W = sarx_pkg::SMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ws_edge,
    input  logic             sdata,
    output logic [SMP_W-1:0] word_o
);
    localparam int                POS_W    = $clog2(SMP_W + 1);
    localparam logic [POS_W-1:0] POS_FULL = POS_W'(SMP_W);

    logic [SMP_W-1:0] acc;
    logic [POS_W-1:0] pos;
    logic             room;

    assign room = (pos < POS_FULL);

    // the bit on the change edge still belongs to the finishing word
    always_comb begin
        word_o = acc;
        for (int b = 0; b < SMP_W; b++) begin
            if (room && ((SMP_W - 1 - b) == int'(pos))) begin
                word_o[b] = sdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ws_edge) begin
            acc <= '0;
            pos <= '0;
        end else if (room) begin
            for (int b = 0; b < SMP_W; b++) begin
                if ((SMP_W - 1 - b) == int'(pos)) begin
                    acc[b] <= sdata;
                end
            end
            pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/sarx_rj_capture.sv
module sarx_rj_capture #(
    parameter int SMP_W = sarx_pkg::SMP_W,
    parameter int RJ_W  = sarx_pkg::RJ_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sdata,
    output logic [SMP_W-1:0] word_o
);
    logic [RJ_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            sr <= {sr[RJ_W-2:0], sdata};
        end
    end

    generate
        if (SMP_W > RJ_W) begin : g_pad
            assign word_o = {sr, {(SMP_W - RJ_W){1'b0}}};
        end else begin : g_cut
            assign word_o = sr[RJ_W-1 -: SMP_W];
        end
    endgenerate

endmodule

// File: rtl/sarx_pair_out.sv
module sarx_pair_out #(
    parameter int SMP_W = sarx_pkg::SMP_W,
    parameter int RJ_W  = sarx_pkg::RJ_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_i2s,
    input  logic             ws,
    input  logic             ws_edge,
    input  logic             half_whole,
    input  logic             half_is16,
    input  logic [SMP_W-1:0] word_i,
    output logic             pair_valid,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             short_o
);
    import sarx_pkg::*;

    logic             left_lvl;
    logic             fin_left;
    logic             fin_right;
    logic             both16;
    logic [SMP_W-1:0] left_q;
    logic             left16_q;
    logic             left_ok;

    function automatic logic [SMP_W-1:0] trim(input logic [SMP_W-1:0] w, input logic en);
        logic [SMP_W-1:0] m;
        m = en ? ({SMP_W{1'b1}} << (SMP_W - RJ_W)) : {SMP_W{1'b1}};
        return w & m;
    endfunction

    assign left_lvl  = left_level(fmt_e'(fmt_i2s));
    assign fin_left  = ws_edge && half_whole && (ws != left_lvl);
    assign fin_right = ws_edge && half_whole && (ws == left_lvl);
    assign both16    = left16_q && half_is16;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_valid <= 1'b0;
            left_o     <= '0;
            right_o    <= '0;
            short_o    <= 1'b0;
            left_q     <= '0;
            left16_q   <= 1'b0;
            left_ok    <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (fin_left) begin
                left_q   <= word_i;
                left16_q <= half_is16;
                left_ok  <= 1'b1;
            end
            if (fin_right && left_ok) begin
                left_o     <= trim(left_q, both16);
                right_o    <= trim(word_i, both16);
                short_o    <= both16;
                pair_valid <= 1'b1;
                left_ok    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int SMP_W     = sarx_pkg::SMP_W,
    parameter int RJ_W      = sarx_pkg::RJ_W,
    parameter int PACK_CLKS = sarx_pkg::PACK_CLKS,
    parameter int HCNT_W    = sarx_pkg::HCNT_W
) (
    input  logic             clk_bit,
    input  logic             rst,
    input  logic             fmt_i2s,
    input  logic             ws,
    input  logic             sdata,
    output logic             pair_valid,
    output logic [SMP_W-1:0] left_smp,
    output logic [SMP_W-1:0] right_smp,
    output logic             pair_short
);
    logic             ws_edge;
    logic             half_whole;
    logic             half_is16;
    logic [SMP_W-1:0] dly_word;
    logic [SMP_W-1:0] rj_word;
    logic [SMP_W-1:0] sel_word;

    sarx_half_timer #(.HCNT_W(HCNT_W), .PACK_CLKS(PACK_CLKS)) u_timer (
        .clk        (clk_bit),
        .rst        (rst),
        .ws         (ws),
        .ws_edge    (ws_edge),
        .half_whole (half_whole),
        .half_is16  (half_is16)
    );

    sarx_i2s_capture #(.SMP_W(SMP_W)) u_dly (
        .clk     (clk_bit),
        .rst     (rst),
        .ws_edge (ws_edge),
        .sdata   (sdata),
        .word_o  (dly_word)
    );

    sarx_rj_capture #(.SMP_W(SMP_W), .RJ_W(RJ_W)) u_rj (
        .clk    (clk_bit),
        .rst    (rst),
        .sdata  (sdata),
        .word_o (rj_word)
    );

    assign sel_word = fmt_i2s ? dly_word : rj_word;

    sarx_pair_out #(.SMP_W(SMP_W), .RJ_W(RJ_W)) u_pair (
        .clk        (clk_bit),
        .rst        (rst),
        .fmt_i2s    (fmt_i2s),
        .ws         (ws),
        .ws_edge    (ws_edge),
        .half_whole (half_whole),
        .half_is16  (half_is16),
        .word_i     (sel_word),
        .pair_valid (pair_valid),
        .left_o     (left_smp),
        .right_o    (right_smp),
        .short_o    (pair_short)
    );

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
    parameter int SMP_W = sarx_pkg::SMP_W,
    parameter int RJ_W  = sarx_pkg::RJ_W
) (
    input logic             clk,
    input logic             rst,
    input logic             fmt_i2s,
    input logic             ws,
    input logic             pair_valid,
    input logic [SMP_W-1:0] left_smp,
    input logic [SMP_W-1:0] right_smp,
    input logic             pair_short
);
    localparam int LO_W = SMP_W - RJ_W;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid); // R8

    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(left_smp) && $stable(right_smp) && $stable(pair_short))); // R8

    AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && pair_short) |-> ((left_smp[LO_W-1:0] == '0) && (right_smp[LO_W-1:0] == '0))); // R7

    AST_RJ_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && !fmt_i2s) |-> ((left_smp[LO_W-1:0] == '0) && (right_smp[LO_W-1:0] == '0))); // R5

    AST_STROBE_ON_LEFT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> ($past(ws) == (fmt_i2s ? 1'b0 : 1'b1))); // R9

endmodule

bind serial_audio_rx sarx_checker #(.SMP_W(SMP_W), .RJ_W(RJ_W)) u_sarx_chk (
    .clk        (clk_bit),
    .rst        (rst),
    .fmt_i2s    (fmt_i2s),
    .ws         (ws),
    .pair_valid (pair_valid),
    .left_smp   (left_smp),
    .right_smp  (right_smp),
    .pair_short (pair_short)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [23:0] l;
        logic [23:0] r;
        logic        pk;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_i2s = 1'b1;
    logic        ws = 1'b0;
    logic        sdata = 1'b0;
    logic        pair_valid;
    logic [23:0] left_smp;
    logic [23:0] right_smp;
    logic        pair_short;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    logic  carry = 1'b0;
    logic  prev_valid = 1'b0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_audio_rx uut (
        .clk_bit    (clk),
        .rst        (rst),
        .fmt_i2s    (fmt_i2s),
        .ws         (ws),
        .sdata      (sdata),
        .pair_valid (pair_valid),
        .left_smp   (left_smp),
        .right_smp  (right_smp),
        .pair_short (pair_short)
    );

    // monitor: pops an expected pair for every strobe seen
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (pair_valid) begin
                checks++;
                if (prev_valid) begin
                    errors++;
                    $display("FAIL R8 strobe wider than one cycle: actual=2 cycles expected=1");
                end else if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected pair: actual l=%h r=%h expected none", left_smp, right_smp);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (left_smp !== e.l || right_smp !== e.r || pair_short !== e.pk) begin
                        errors++;
                        $display("FAIL %s: actual l=%h r=%h pk=%b expected l=%h r=%h pk=%b",
                                 t, left_smp, right_smp, pair_short, e.l, e.r, e.pk);
                    end
                end
            end
            prev_valid = pair_valid;
        end else begin
            prev_valid = 1'b0;
        end
    end

    function automatic logic dly_bit(input logic [23:0] w, input int nb, input int j);
        if (j < nb) return w[nb-1-j];
        if (j < 24) return 1'b0;
        return 1'b1; // junk after the 24th bit
    endfunction

    function automatic logic rj_bit(input logic [15:0] w, input int n, input int i);
        if (i >= n - 16) return w[15-(i-(n-16))];
        return 1'b1; // junk before the last 16 clocks
    endfunction

    task automatic dly_half(input logic lvl, input int n, input logic [23:0] w, input int nb);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ws    = lvl;
            sdata = (i == 0) ? carry : dly_bit(w, nb, i - 1);
        end
        carry = dly_bit(w, nb, n - 1);
    endtask

    task automatic rj_half(input logic lvl, input int n, input logic [15:0] w);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ws    = lvl;
            sdata = rj_bit(w, n, i);
        end
    endtask

    task automatic dly_frame(input int ln, input logic [23:0] lw, input int lb,
                             input int rn, input logic [23:0] rw, input int rb, input string tag);
        exp_t e;
        e.pk = (ln == 16) && (rn == 16);
        e.l  = 24'(lw << (24 - lb));
        e.r  = 24'(rw << (24 - rb));
        if (e.pk) begin
            e.l[7:0] = 8'h00;
            e.r[7:0] = 8'h00;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        dly_half(1'b0, ln, lw, lb);
        dly_half(1'b1, rn, rw, rb);
    endtask

    task automatic rj_frame(input int ln, input logic [15:0] lw, input int rn, input logic [15:0] rw,
                            input string tag);
        exp_t e;
        e.pk = (ln == 16) && (rn == 16);
        e.l  = {lw, 8'h00};
        e.r  = {rw, 8'h00};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rj_half(1'b1, ln, lw);
        rj_half(1'b0, rn, rw);
    endtask

    task automatic start_stream(input logic fmt, input logic lead_lvl, input int lead_n);
        @(negedge clk);
        rst     = 1'b1;
        fmt_i2s = fmt;
        ws      = lead_lvl;
        sdata   = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (pair_valid !== 1'b0 || left_smp !== 24'h0 || right_smp !== 24'h0 || pair_short !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: actual v=%b l=%h r=%h pk=%b expected all zero",
                     pair_valid, left_smp, right_smp, pair_short);
        end
        rst = 1'b0;
        carry = 1'b1;
        for (int i = 0; i < lead_n; i++) begin
            ws    = lead_lvl;
            sdata = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic end_stream(input logic fmt, input string tag);
        if (fmt) dly_half(1'b0, 6, 24'h0, 0);
        else     rj_half(1'b1, 6, 16'h0);
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing pairs: actual outstanding=%0d expected 0", tag, exp_q.size());
        end
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        // delayed-MSB framing, word clock low = left (R2, R9)
        start_stream(1'b1, 1'b1, 9);
        dly_frame(32, 24'hA5C3E1, 24, 32, 24'h5A3C1E, 24, "R2 R9 32-clock halves");
        dly_frame(24, 24'h123456, 24, 24, 24'hFEDCBA, 24, "R2 last bit on next half edge");
        dly_frame(32, 24'h0ABCDE, 20, 32, 24'h02B3C4, 18, "R3 zero fill short words");
        dly_frame(25, 24'h89ABCD, 24, 40, 24'h7E8F90, 24, "R4 junk after 24th bit");
        dly_frame(16, 24'h00BEEF, 16, 16, 24'h00C0DE, 16, "R7 packed 16-clock frame");
        dly_frame(16, 24'h001234, 16, 20, 24'h0000FF, 16, "R7 unequal halves not packed");
        dly_frame(16, 24'h00F00D, 16, 16, 24'h008001, 16, "R7 packed again");
        end_stream(1'b1, "R2");

        // right-justified framing, word clock high = left (R5, R9)
        start_stream(1'b0, 1'b0, 7);
        rj_frame(32, 16'hCAFE, 32, 16'h1357, "R5 R6 R9 32-clock halves");
        rj_frame(16, 16'hBEAD, 16, 16'h2468, "R5 R7 packed");
        rj_frame(20, 16'h8000, 48, 16'h0001, "R6 leading junk ignored");
        rj_frame(17, 16'h7FFF, 16, 16'hFFFF, "R7 one half 17 clocks");
        end_stream(1'b0, "R5");

        // stream begins inside a left half: first right word must be dropped (R1)
        start_stream(1'b1, 1'b0, 11);
        dly_half(1'b1, 32, 24'h777777, 24);
        dly_frame(32, 24'h314159, 24, 32, 24'h271828, 24, "R1 first whole frame after partial");
        end_stream(1'b1, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule